// File: doc/BRIEF.md
# Dual-Level Interrupt Enable Controller

This block merges six interrupt sources onto two active-low CPU interrupt lines. One line is the normal request (IRQ) and the other is the fast request (FIRQ). Three sources are external active-low level pins: serial input, keyboard and cartridge. The other three are single-cycle pulses from inside the chip: the timer zero crossing, the horizontal border and the vertical border. Each line has its own 6-bit source enable register. A global gate bit in a shared control register sits above each line's enables. A source may be enabled on both lines at the same time.

When an enable register is read, the value returned is a status word and not the stored enables. A bit reads as 1 when that source is enabled in that register and is requesting. An external source requests while its pin is low. An internal source requests while its pending latch is set. Each line has its own set of pending latches for the three internal sources. A latch is set by a pulse only when the source is enabled on that line. It is cleared when that line's enable register is read or written. Software reads the status to find the cause of an interrupt, and the read also acknowledges the internal events.

Top module: `irq_enable_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, all enables, both global gates and all pending latches are zero. Both interrupt lines are high and both status reads return 0.
- R2: Status and enable bits use this order: bit 5 timer, bit 4 horizontal border, bit 3 vertical border, bit 2 serial input, bit 1 keyboard, bit 0 cartridge. `rd_sel` = 0 selects the IRQ status and `rd_sel` = 1 selects the FIRQ status.
- R3: An external source's status bit reads 1 while its enable is set and its pin is low. It reads 0 in the same cycle the pin returns high, and nothing is latched.
- R4: A pulse on an internal source sets that line's pending latch at the next clock edge only if the source is enabled in that line's register. A pulse while disabled leaves no trace. Every further pulse sets the latch again without any re-enabling.
- R5: An access with `rd_en` high clears, at that clock edge, the internal pending latches of the line picked by `rd_sel`. The other line's latches are unchanged. The value read in that cycle is the status before the clear.
- R6: A write selects its target with `wr_sel`: 0 is the control register (`wr_data[5]` is the IRQ gate, `wr_data[4]` is the FIRQ gate), 1 is the IRQ enables (`wr_data[5:0]`), 2 is the FIRQ enables, and 3 is ignored. A write to an enable register clears that line's internal pending latches.
- R7: If a pulse for an enabled source arrives in the same cycle as a clearing read or write, the set takes priority. The pulse is tested against the enable value held before the write.
- R8: `irq_n` is low exactly when the IRQ gate is set and the IRQ status is nonzero. `firq_n` follows the same rule with the FIRQ gate and the FIRQ status. Both are combinational from the current state and pins.
- R9: A source enabled in both registers reads as set in both statuses and can pull both lines low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 IRQ enables, 2 FIRQ enables |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Status read strobe (clears the selected line's latches) |
| rd_sel | input | 1 | Status select: 0 IRQ, 1 FIRQ |
| rd_data | output | 6 | Status of the selected line |
| tmr_pulse | input | 1 | Timer zero-crossing pulse |
| hbord_pulse | input | 1 | Horizontal border pulse |
| vbord_pulse | input | 1 | Vertical border pulse |
| serial_n | input | 1 | Serial input request, active low |
| key_n | input | 1 | Keyboard request, active low |
| cart_n | input | 1 | Cartridge request, active low |
| irq_n | output | 1 | Normal interrupt line, active low |
| firq_n | output | 1 | Fast interrupt line, active low |

## Verification
The hardest case to reach is a pulse that lands in the same cycle as a clearing read or write of its own line, while the other line holds the same source pending. This is the only place where the set-over-clear rule and the separation of the two lines' latches are both visible. Directed steps build this case on purpose: the timer is enabled on both lines, a pulse is latched, and then a read of one line coincides with a second pulse. A long run of seeded random strobes, selects, pulses and pin levels is then compared every cycle against a bench model of the latches, enables and gates.

// File: rtl/irq_enable_ctrl.sv
module irq_enable_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  input  logic       rd_sel,
  output logic [5:0] rd_data,
  input  logic       tmr_pulse,
  input  logic       hbord_pulse,
  input  logic       vbord_pulse,
  input  logic       serial_n,
  input  logic       key_n,
  input  logic       cart_n,
  output logic       irq_n,
  output logic       firq_n
);
  logic       gate_i, gate_f;
  logic [5:0] irq_en, firq_en;
  logic [2:0] irq_lat, firq_lat;
  logic [2:0] pulses, ext_req;
  logic [5:0] irq_stat, firq_stat;
  logic       clr_i, clr_f;

  // R2 order: {timer, hborder, vborder, serial, keyboard, cartridge}
  assign pulses  = {tmr_pulse, hbord_pulse, vbord_pulse};
  assign ext_req = ~{serial_n, key_n, cart_n};

  assign irq_stat  = irq_en  & {irq_lat,  ext_req};
  assign firq_stat = firq_en & {firq_lat, ext_req};
  assign rd_data   = rd_sel ? firq_stat : irq_stat;

  assign irq_n  = ~(gate_i & |irq_stat);
  assign firq_n = ~(gate_f & |firq_stat);

  assign clr_i = (rd_en && !rd_sel) || (wr_en && wr_sel == 2'd1);
  assign clr_f = (rd_en &&  rd_sel) || (wr_en && wr_sel == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_lat  <= '0;
      firq_lat <= '0;
    end else begin
      irq_lat  <= (clr_i ? 3'b000 : irq_lat)  | (pulses & irq_en[5:3]);
      firq_lat <= (clr_f ? 3'b000 : firq_lat) | (pulses & firq_en[5:3]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_i  <= 1'b0;
      gate_f  <= 1'b0;
      irq_en  <= '0;
      firq_en <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: begin
          gate_i <= wr_data[5];
          gate_f <= wr_data[4];
        end
        2'd1: irq_en  <= wr_data[5:0];
        2'd2: firq_en <= wr_data[5:0];
        default: ;
      endcase
    end
  end
endmodule

module irq_enable_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_sel,
  input logic       rd_en,
  input logic       rd_sel,
  input logic       tmr_pulse,
  input logic       hbord_pulse,
  input logic       vbord_pulse,
  input logic       irq_n,
  input logic       firq_n,
  input logic       gate_i,
  input logic       gate_f,
  input logic [5:0] irq_en,
  input logic [5:0] firq_en,
  input logic [2:0] irq_lat,
  input logic [2:0] firq_lat
);
  logic no_pulse;
  assign no_pulse = !tmr_pulse && !hbord_pulse && !vbord_pulse;

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (irq_en == 6'd0 && firq_en == 6'd0 && irq_lat == 3'd0 && firq_lat == 3'd0));

  assert_timer_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_pulse && irq_en[5]) |=> irq_lat[2]);

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel && no_pulse) |=> firq_lat == 3'd0);

  assert_read_keeps_other_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel && !wr_en && no_pulse) |=> irq_lat == $past(irq_lat));

  assert_write_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd1 && no_pulse) |=> irq_lat == 3'd0);

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vbord_pulse && firq_en[3] && rd_en && rd_sel) |=> firq_lat[0]);

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> gate_i);

  assert_firq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !firq_n |-> gate_f);
endmodule

bind irq_enable_ctrl irq_enable_ctrl_chk u_chk (.*);

// File: tb/tb_irq_enable_ctrl.sv
module tb_irq_enable_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, rd_sel = 0;
  logic [1:0] wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic tmr_pulse = 0, hbord_pulse = 0, vbord_pulse = 0;
  logic serial_n = 1, key_n = 1, cart_n = 1;
  logic [5:0] rd_data;
  logic irq_n, firq_n;

  int checks = 0, errors = 0;
  bit done = 0;

  logic       m_gi, m_gf;
  logic [5:0] m_en [2];
  logic [2:0] m_lat [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_enable_ctrl dut (.*);

  function automatic logic [5:0] mstat(input int s);
    return m_en[s] & {m_lat[s], ~serial_n, ~key_n, ~cart_n};
  endfunction

  task automatic check(input string tag, input string what, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_gi = 0; m_gf = 0;
    for (int s = 0; s < 2; s++) begin m_en[s] = 0; m_lat[s] = 0; end
  endtask

  task automatic step(input string tag, input logic we, input logic [1:0] ws, input logic [7:0] wd,
                      input logic re, input logic rs, input logic [2:0] pul, input logic [2:0] pins_n);
    wr_en = we; wr_sel = ws; wr_data = wd; rd_en = re; rd_sel = rs;
    {tmr_pulse, hbord_pulse, vbord_pulse} = pul;
    {serial_n, key_n, cart_n} = pins_n;
    #1;
    check(tag, "rd_data", rd_data, mstat(rs ? 1 : 0));
    check(tag, "irq_n (R8)", {5'd0, irq_n}, {5'd0, ~(m_gi & |mstat(0))});
    check(tag, "firq_n (R8)", {5'd0, firq_n}, {5'd0, ~(m_gf & |mstat(1))});
    @(posedge clk);
    for (int s = 0; s < 2; s++) begin
      logic clr;
      clr = (re && (rs == s[0])) || (we && ws == 2'(s + 1));
      m_lat[s] = (clr ? 3'b000 : m_lat[s]) | (pul & m_en[s][5:3]);
    end
    if (we) begin
      case (ws)
        2'd0: begin m_gi = wd[5]; m_gf = wd[4]; end
        2'd1: m_en[0] = wd[5:0];
        2'd2: m_en[1] = wd[5:0];
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic idle(input string tag, input logic rs);
    step(tag, 0, 0, 0, 0, rs, 3'b000, 3'b111);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    check("R1", "rd_data in reset", rd_data, 6'd0);
    check("R1", "irq_n in reset", {5'd0, irq_n}, 6'd1);
    check("R1", "firq_n in reset", {5'd0, firq_n}, 6'd1);
    rst_n = 1;
    @(negedge clk);
    idle("R1", 0);
    idle("R1", 1);

    // R6: gates on; R3 keyboard level on IRQ only
    step("R6", 1, 2'd0, 8'h30, 0, 0, 3'b000, 3'b111);
    step("R6", 1, 2'd1, 8'h02, 0, 0, 3'b000, 3'b111);
    step("R3", 0, 0, 0, 0, 0, 3'b000, 3'b101);
    check("R3", "keyboard status bit1", rd_data, 6'h02);
    step("R3", 0, 0, 0, 0, 1, 3'b000, 3'b101);
    step("R3", 0, 0, 0, 0, 0, 3'b000, 3'b111);
    check("R3", "released pin", rd_data, 6'h00);
    step("R6", 1, 2'd3, 8'hFF, 0, 0, 3'b000, 3'b111);

    // R4: pulse while disabled leaves nothing, then enable
    step("R4", 0, 0, 0, 0, 0, 3'b100, 3'b111);
    step("R4", 1, 2'd1, 8'h20, 0, 0, 3'b000, 3'b111);
    idle("R4", 0);
    check("R4", "no trace of disabled pulse", rd_data, 6'h00);
    // R9: timer on both lines
    step("R9", 1, 2'd2, 8'h20, 0, 0, 3'b000, 3'b111);
    step("R9", 0, 0, 0, 0, 0, 3'b100, 3'b111);
    idle("R9", 0);
    check("R9", "IRQ sees timer", rd_data, 6'h20);
    check("R9", "irq_n low", {5'd0, irq_n}, 6'd0);
    check("R9", "firq_n low", {5'd0, firq_n}, 6'd0);
    // R5: read IRQ clears only IRQ
    step("R5", 0, 0, 0, 1, 0, 3'b000, 3'b111);
    idle("R5", 0);
    check("R5", "IRQ cleared", rd_data, 6'h00);
    idle("R5", 1);
    check("R5", "FIRQ kept", rd_data, 6'h20);
    // R7: read FIRQ with a timer pulse in the same cycle
    step("R7", 0, 0, 0, 1, 1, 3'b100, 3'b111);
    idle("R7", 1);
    check("R7", "set wins over read clear", rd_data, 6'h20);
    // R2: border bits
    step("R2", 1, 2'd1, 8'h18, 0, 0, 3'b011, 3'b111);
    step("R2", 0, 0, 0, 0, 0, 3'b011, 3'b110);
    step("R2", 1, 2'd1, 8'h19, 0, 0, 3'b000, 3'b110);
    step("R2", 0, 0, 0, 0, 0, 3'b000, 3'b110);
    // R8: gate off hides requests
    step("R8", 1, 2'd0, 8'h10, 0, 0, 3'b000, 3'b011);
    step("R8", 0, 0, 0, 0, 0, 3'b000, 3'b011);

    // random mix
    seed = 32'd12345;
    void'($urandom(seed));
    for (int i = 0; i < 4000; i++) begin
      logic we, re, rs;
      logic [1:0] ws;
      logic [7:0] wd;
      logic [2:0] pul, pins;
      we = ($urandom % 6) == 0;
      ws = 2'($urandom);
      wd = 8'($urandom);
      re = ($urandom % 4) == 0;
      rs = 1'($urandom);
      pul = {($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0};
      pins = {($urandom % 3) != 0, ($urandom % 3) != 0, ($urandom % 3) != 0};
      step("R2", we, ws, wd, re, rs, pul, pins);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule